// File: doc/BRIEF.md
# Threshold Watchdog Timer Pair

This block holds two watchdog timers that share one 32-bit register port. Each timer counts up from zero, one step per timebase tick, and is fixed to a nominal 10 ms period by a clock divider parameter. When the count reaches a programmable 15-bit threshold, the timer is expired. The count then holds at the threshold until software writes the timer's word again. Any write to a timer's word restarts that timer. The write clears the count and the tick divider, and it loads a new threshold and action bit.

The two timers differ only in what their action bit drives. On timer 0, the action bit arms a system reset request that is raised while the timer is expired. On timer 1, the action bit arms a degraded-mode flag while the timer is expired. Downstream traffic logic uses that flag to stop delivering CPU-bound frames and to turn off flow control. The register read path is combinational, so the word of the selected timer is always visible.

Top module: `tick_wdog`

## Requirements
- R1: While reset is held, and after it is applied, each timer's word reads 32'h7FFF_0000 (action bit 0, threshold 0x7FFF, count 0), and all four outputs are low.
- R2: The word layout is: bit 31 is the action bit, bits 30:16 are the threshold, bit 15 always reads 0, and bits 14:0 are the running count. `reg_sel` picks timer 0 or timer 1 for both reads and writes.
- R3: After a write, the count goes up by exactly one every TICK_DIV clock cycles. After the m-th rising edge that follows the edge capturing the write, the count equals floor(m / TICK_DIV) until it reaches the threshold.
- R4: A write clears the count and restarts the tick divider, whatever state the timer was in. Bits 15:0 of the write data have no effect.
- R5: A timer's expired output is high exactly when its count equals its threshold. It stays high until the next write to that timer.
- R6: Once the count reaches the threshold, it holds there and never goes past it.
- R7: `rst_req` is high exactly when timer 0 is expired and its action bit is 1. With the action bit at 0, expiry raises `expired0` only.
- R8: `degrade` is high exactly when timer 1 is expired and its action bit is 1.
- R9: A write to one timer leaves the other timer's count, threshold and outputs unchanged.
- R10: A threshold of 0 makes the timer expired from the first sample after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Timer select: 0 = timer 0, 1 = timer 1 |
| reg_we | input | 1 | Write strobe for the selected timer's word |
| reg_wdata | input | 32 | Write data; bit 31 is the action bit, bits 30:16 are the threshold |
| reg_rdata | output | 32 | Word of the selected timer (combinational) |
| expired0 | output | 1 | Timer 0 count has reached its threshold |
| rst_req | output | 1 | System reset request from timer 0 |
| expired1 | output | 1 | Timer 1 count has reached its threshold |
| degrade | output | 1 | Degraded traffic mode flag from timer 1 |

## Verification
A write takes effect on the rising edge that captures `reg_we`, so the word read at the following falling edge already shows a cleared count and the new threshold. The count, the expired outputs and the action outputs then change only on rising edges that are exact multiples of TICK_DIV after that capture edge, because all four outputs are decoded from the registers with no added delay. The bench samples at every falling edge after each write and compares against min(floor(m / TICK_DIV), threshold). This sweeps every threshold from 0 to 5 on both timers with both action-bit values, and it checks the unselected timer at each of those samples.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Field widths fixed by the register layout
  localparam int CNT_W  = 15;
  localparam int NUM_CH = 2;
  localparam logic [CNT_W-1:0] THR_RST = '1;

  typedef struct packed {
    logic             act;
    logic [CNT_W-1:0] thr;
    logic             rsvd;
    logic [CNT_W-1:0] cnt;
  } wdt_word_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned TICK_DIV = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick_o = (pre_q == LAST);

  always_comb begin
    if (restart_i || tick_o) pre_d = '0;
    else                     pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
endmodule

// File: rtl/wdt_chan.sv
module wdt_chan
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 500000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_i,
  input  logic [15:0] cfg_i,
  output wdt_word_t word_o,
  output logic      expired_o,
  output logic      action_o
);
  logic             tick;
  logic             act_q, act_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  wdt_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wr_i),
    .tick_o    (tick)
  );

  assign expired_o = (cnt_q == thr_q);
  assign action_o  = act_q & expired_o;
  assign upd_en    = wr_i | (tick & ~expired_o);

  always_comb begin
    act_d = act_q;
    thr_d = thr_q;
    cnt_d = cnt_q;
    if (wr_i) begin
      act_d = cfg_i[15];
      thr_d = cfg_i[CNT_W-1:0];
      cnt_d = '0;
    end else if (tick && !expired_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      thr_q <= THR_RST;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      thr_q <= thr_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    word_o.act  = act_q;
    word_o.thr  = thr_q;
    word_o.rsvd = 1'b0;
    word_o.cnt  = cnt_q;
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == '0));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !wr_i) |=> expired_o);
  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_wdog.sv
module tick_wdog
  import wdt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        expired0,
  output logic        rst_req,
  output logic        expired1,
  output logic        degrade
);
  logic                  rst_sync_n;
  wdt_word_t             words   [NUM_CH];
  logic [NUM_CH-1:0]     expired;
  logic [NUM_CH-1:0]     action;
  logic                  unused_lowbits;

  assign unused_lowbits = ^reg_wdata[15:0];

  wdt_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    wdt_chan #(.TICK_DIV(TICK_DIV)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_i      (reg_we && (reg_sel == 1'(g))),
      .cfg_i     (reg_wdata[31:16]),
      .word_o    (words[g]),
      .expired_o (expired[g]),
      .action_o  (action[g])
    );
  end

  assign reg_rdata = words[reg_sel];
  assign expired0  = expired[0];
  assign rst_req   = action[0];
  assign expired1  = expired[1];
  assign degrade   = action[1];

  p_rstreq_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_req |-> expired0);
  p_degrade_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    degrade |-> expired1);
  p_isolate_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_we && reg_sel) |=> $stable(rst_req));
endmodule

// File: tb/tick_wdog_test.sv
module tick_wdog_test;
  localparam int P = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        expired0, rst_req, expired1, degrade;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  tick_wdog #(.TICK_DIV(P)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .expired0  (expired0),
    .rst_req   (rst_req),
    .expired1  (expired1),
    .degrade   (degrade)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  // write captured at next rising edge; returns at the falling edge after it (m = 0)
  task automatic wr(input logic ch, input logic [31:0] data);
    @(negedge clk);
    reg_sel   = ch;
    reg_wdata = data;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < 2; c++) begin
      reg_sel = 1'(c);
      #1;
      chk(reg_rdata == 32'h7FFF_0000, "R1 reset word", reg_rdata, 32'h7FFF_0000);
    end
    chk({expired0, rst_req, expired1, degrade} == 4'b0, "R1 reset outputs",
        {28'd0, expired0, rst_req, expired1, degrade}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int ch = 0; ch < 2; ch++) begin
      if (ch == 1) begin
        // R9 setup: timer 0 expired and armed, must stay so during timer 1 sweeps
        wr(1'b0, 32'h8000_0000);
      end
      for (int ctl = 0; ctl < 2; ctl++) begin
        for (int t = 0; t < 6; t++) begin
          logic [31:0] wdat;
          wdat = {1'(ctl), 15'(t), 16'hFFFF};  // R4: low bits must be ignored
          wr(1'(ch), wdat);
          for (int m = 0; m <= P * (t + 2); m++) begin
            int   ecnt;
            logic eexp, eact, gexp, gact;
            logic [31:0] ew;
            if (m > 0) @(negedge clk);
            ecnt = (m / P < t) ? m / P : t;
            ew   = {1'(ctl), 15'(t), 1'b0, 15'(ecnt)};
            eexp = (ecnt == t);
            eact = eexp && (ctl == 1);
            gexp = (ch == 0) ? expired0 : expired1;
            gact = (ch == 0) ? rst_req  : degrade;
            chk(reg_rdata == ew, (m == 0) ? "R4 R10 clear/load" : "R3 R6 count",
                reg_rdata, ew);
            chk(gexp == eexp, "R5 expired", {31'd0, gexp}, {31'd0, eexp});
            chk(gact == eact, (ch == 0) ? "R7 rst_req" : "R8 degrade",
                {31'd0, gact}, {31'd0, eact});
            if (ch == 0)
              chk({expired1, degrade} == 2'b00, "R9 timer1 untouched",
                  {30'd0, expired1, degrade}, 32'd0);
            else
              chk({expired0, rst_req} == 2'b11, "R9 timer0 untouched",
                  {30'd0, expired0, rst_req}, 32'd3);
          end
        end
      end
    end

    // R2: read of the other timer through reg_sel shows timer 0's word
    reg_sel = 1'b0;
    #1;
    chk(reg_rdata == 32'h8000_0000, "R2 select timer0", reg_rdata, 32'h8000_0000);
    finish_run();
  end
endmodule